// File: doc/BRIEF.md
# Receiver Idle Time-out Counter

This block watches a serial receiver for silence on the line. A programmed number of bit periods is loaded into a countdown register. The count drops by one on each bit-period tick and is reloaded whenever the receiver reports a complete character. If the count runs all the way down, a sticky time-out flag is set and a one-cycle interrupt pulse is produced. Slave-node software uses this flag to decide when the bus is idle and the node can go to sleep.

Two commands set how the countdown restarts. The start-on-character command reloads the value and freezes the countdown until the next character arrives. The restart-now command reloads the value and starts counting down at once. A programmed value of zero disables detection. Typical limits are 25000 bit times for the older bus revision, or the bit-time count equal to four seconds for the newer one. The default 17-bit width holds either limit at low baud rates.

Top module: `rx_idle_timeout`

## Requirements
- R1: While reset is asserted and after its release, `timeout_o` and `timeout_irq_o` are 0, and the countdown is frozen. Ticks after reset never set the flag until a character or a restart-now command arrives.
- R2: A `cmd_restart_now` pulse loads `to_value` and starts the countdown at once. With `to_value`=V>0, `timeout_o` rises in the clock cycle after the V-th `bit_tick` pulse that follows the command.
- R3: With `to_value`=0, `timeout_o` and `timeout_irq_o` stay 0 for any number of ticks.
- R4: A `char_rx` pulse reloads the count from `to_value`. V further ticks are then needed before `timeout_o` rises.
- R5: `timeout_irq_o` is high for exactly one cycle, in the same cycle that `timeout_o` first reads 1.
- R6: Once the count reaches 0 it stays at 0 and does not wrap. Further ticks produce no new interrupt pulse.
- R7: After `cmd_start_on_char`, ticks have no effect until a `char_rx` pulse arrives. After that, V ticks set `timeout_o`.
- R8: `timeout_o` stays set until `stat_clr`, `cmd_restart_now` or `cmd_start_on_char` is pulsed, and is 0 in the cycle after any of these. After `stat_clr`, further ticks do not set it again without a reload.
- R9: When `char_rx` and `bit_tick` are high in the same cycle, the reload wins and the decrement is dropped. V more ticks are then needed.
- R10: `cmd_restart_now` takes priority over `cmd_start_on_char`, which takes priority over `char_rx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| char_rx | input | 1 | One-cycle pulse when a character is received |
| to_value | input | CNT_W | Programmed time-out in bit periods; 0 disables |
| cmd_start_on_char | input | 1 | Reload and freeze until the next character |
| cmd_restart_now | input | 1 | Reload and count down at once |
| stat_clr | input | 1 | Clears the sticky flag |
| timeout_o | output | 1 | Sticky time-out flag |
| timeout_irq_o | output | 1 | One-cycle pulse when the flag sets |

## Verification
The bench builds the block with CNT_W=5, so it can try every programmable value from 0 to 31. That sweep covers the disabled value, the single-tick time-out and the all-ones full-scale load. For each value, the bench counts ticks and predicts the exact tick at which the flag and the pulse appear. The small width also makes it cheap to keep ticking past expiry, which shows that the count does not wrap or fire again. Directed sequences cover the frozen mode, a reload in the middle of a count, a character and a tick in the same cycle, and command priority.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
  typedef enum logic {
    RXTO_FROZEN   = 1'b0,
    RXTO_COUNTING = 1'b1
  } rxto_run_e;

  typedef struct packed {
    logic      load;
    logic      clr_flag;
    rxto_run_e run;
  } rxto_ctl_s;
endpackage

// File: rtl/rxto_ctrl.sv
module rxto_ctrl
  import rxto_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      char_rx,
  input  logic      cmd_start_on_char,
  input  logic      cmd_restart_now,
  input  logic      stat_clr,
  output rxto_ctl_s ctl
);
  rxto_run_e run_q, run_d;
  logic      load_evt;
  logic      clr_evt;

  // restart-now > start-on-char > character
  always_comb begin
    run_d = run_q;
    if (cmd_restart_now)        run_d = RXTO_COUNTING;
    else if (cmd_start_on_char) run_d = RXTO_FROZEN;
    else if (char_rx)           run_d = RXTO_COUNTING;
  end

  assign load_evt = cmd_restart_now | cmd_start_on_char | char_rx;
  assign clr_evt  = stat_clr | cmd_restart_now | cmd_start_on_char;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= RXTO_FROZEN;
    else        run_q <= run_d;
  end

  assign ctl.load     = load_evt;
  assign ctl.clr_flag = clr_evt;
  assign ctl.run      = run_q;

  // R10
  restart_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_restart_now |=> run_q == RXTO_COUNTING);
  // R7
  freeze_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start_on_char && !cmd_restart_now) |=> run_q == RXTO_FROZEN);
endmodule

// File: rtl/rxto_counter.sv
module rxto_counter
  import rxto_pkg::*;
#(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic [CNT_W-1:0] to_value,
  input  rxto_ctl_s        ctl,
  output logic [CNT_W-1:0] count_q,
  output logic             dec_evt,
  output logic             expire_evt
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  function automatic logic may_dec(input logic tick, input logic running,
                                   input logic load, input logic [CNT_W-1:0] lim,
                                   input logic [CNT_W-1:0] cnt);
    return tick && running && !load && (lim != ZERO) && (cnt != ZERO);
  endfunction

  function automatic logic [CNT_W-1:0] next_count(input logic load,
                                                  input logic dec,
                                                  input logic [CNT_W-1:0] lim,
                                                  input logic [CNT_W-1:0] cnt);
    if (load)     return lim;
    else if (dec) return cnt - ONE;
    else          return cnt;
  endfunction

  logic running;
  assign running    = (ctl.run == RXTO_COUNTING);
  assign dec_evt    = may_dec(bit_tick, running, ctl.load, to_value, count_q);
  assign expire_evt = dec_evt && (count_q == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= ZERO;
    else        count_q <= next_count(ctl.load, dec_evt, to_value, count_q);
  end

  // R6
  cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == ZERO && !ctl.load) |=> count_q == ZERO);
  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.load |=> count_q == $past(to_value));
  // R9
  reload_over_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.load && bit_tick) |-> !dec_evt);
endmodule

// File: rtl/rxto_flag.sv
module rxto_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_evt,
  input  logic clr_flag,
  output logic flag_q,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= expire_evt;
      if (expire_evt)    flag_q <= 1'b1;
      else if (clr_flag) flag_q <= 1'b0;
    end
  end

  // R5
  irq_implies_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> flag_q);
  // R5
  rise_has_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> irq_q);
  // R5
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_flag && !expire_evt) |=> !flag_q);
endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout
  import rxto_pkg::*;
#(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             char_rx,
  input  logic [CNT_W-1:0] to_value,
  input  logic             cmd_start_on_char,
  input  logic             cmd_restart_now,
  input  logic             stat_clr,
  output logic             timeout_o,
  output logic             timeout_irq_o
);
  rxto_ctl_s        ctl;
  logic [CNT_W-1:0] count;
  logic             dec_evt;
  logic             expire_evt;

  rxto_ctrl u_ctrl (
    .clk               (clk),
    .rst_n             (rst_n),
    .char_rx           (char_rx),
    .cmd_start_on_char (cmd_start_on_char),
    .cmd_restart_now   (cmd_restart_now),
    .stat_clr          (stat_clr),
    .ctl               (ctl)
  );

  rxto_counter #(.CNT_W(CNT_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .to_value   (to_value),
    .ctl        (ctl),
    .count_q    (count),
    .dec_evt    (dec_evt),
    .expire_evt (expire_evt)
  );

  rxto_flag u_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .expire_evt (expire_evt),
    .clr_flag   (ctl.clr_flag),
    .flag_q     (timeout_o),
    .irq_q      (timeout_irq_o)
  );

  // R7
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.run == RXTO_FROZEN && !ctl.load) |=> $stable(count));
  // R3
  zero_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (to_value == '0) |-> !expire_evt);
  // R2
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_evt |=> count == $past(count) - CNT_W'(1));
endmodule

// File: tb/rx_idle_timeout_bench.sv
module rx_idle_timeout_bench;
  localparam int W = 5;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bit_tick = 1'b0, char_rx = 1'b0;
  logic [W-1:0] to_value = '0;
  logic         cmd_start_on_char = 1'b0, cmd_restart_now = 1'b0, stat_clr = 1'b0;
  logic         timeout_o, timeout_irq_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_idle_timeout #(.CNT_W(W)) u_rx_idle_timeout (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .char_rx(char_rx),
    .to_value(to_value), .cmd_start_on_char(cmd_start_on_char),
    .cmd_restart_now(cmd_restart_now), .stat_clr(stat_clr),
    .timeout_o(timeout_o), .timeout_irq_o(timeout_irq_o));

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // pulse inputs for one cycle; afterwards outputs reflect that edge
  task automatic pulse(input logic t, input logic c, input logic son,
                       input logic rnow, input logic clr);
    @(negedge clk);
    bit_tick = t; char_rx = c; cmd_start_on_char = son;
    cmd_restart_now = rnow; stat_clr = clr;
    @(negedge clk);
    bit_tick = 0; char_rx = 0; cmd_start_on_char = 0;
    cmd_restart_now = 0; stat_clr = 0;
  endtask

  // n ticks, none of which may set the flag
  task automatic quiet_ticks(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      pulse(1, 0, 0, 0, 0);
      check(timeout_o, 1'b0, req);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(timeout_o, 1'b0, "R1");
    check(timeout_irq_o, 1'b0, "R1");
    rst_n = 1'b1;
    to_value = 5'd3;
    quiet_ticks(6, "R1");

    // sweep every value: R2 R3 R5 R6
    for (int v = 0; v < 32; v++) begin
      to_value = W'(v);
      pulse(0, 0, 0, 1, 0);
      check(timeout_o, 1'b0, "R8");
      for (int n = 1; n <= v + 3; n++) begin
        pulse(1, 0, 0, 0, 0);
        check(timeout_o, (v != 0) && (n >= v), v == 0 ? "R3" : "R2");
        check(timeout_irq_o, (v != 0) && (n == v), n > v ? "R6" : "R5");
      end
      @(negedge clk);
      check(timeout_irq_o, 1'b0, "R5");
    end

    // R8 sticky then clear, no re-set without reload
    to_value = 5'd4;
    pulse(0, 0, 0, 1, 0);
    for (int i = 0; i < 4; i++) pulse(1, 0, 0, 0, 0);
    check(timeout_o, 1'b1, "R8");
    repeat (3) @(negedge clk);
    check(timeout_o, 1'b1, "R8");
    pulse(0, 0, 0, 0, 1);
    check(timeout_o, 1'b0, "R8");
    quiet_ticks(6, "R8");

    // R4 mid-count reload
    to_value = 5'd5;
    pulse(0, 0, 0, 1, 0);
    quiet_ticks(3, "R4");
    pulse(0, 1, 0, 0, 0);
    quiet_ticks(4, "R4");
    pulse(1, 0, 0, 0, 0);
    check(timeout_o, 1'b1, "R4");

    // R7 frozen until character; command also clears flag
    pulse(0, 0, 1, 0, 0);
    check(timeout_o, 1'b0, "R8");
    quiet_ticks(10, "R7");
    pulse(0, 1, 0, 0, 0);
    quiet_ticks(4, "R7");
    pulse(1, 0, 0, 0, 0);
    check(timeout_o, 1'b1, "R7");

    // R9 char and tick together
    to_value = 5'd3;
    pulse(0, 0, 0, 1, 0);
    quiet_ticks(2, "R9");
    pulse(1, 1, 0, 0, 0);
    check(timeout_o, 1'b0, "R9");
    quiet_ticks(2, "R9");
    pulse(1, 0, 0, 0, 0);
    check(timeout_o, 1'b1, "R9");

    // R10 restart beats start-on-char: counts at once
    to_value = 5'd2;
    pulse(0, 0, 1, 1, 0);
    quiet_ticks(1, "R10");
    pulse(1, 0, 0, 0, 0);
    check(timeout_o, 1'b1, "R10");
    // R10 start-on-char beats character: stays frozen
    pulse(0, 1, 1, 0, 0);
    quiet_ticks(5, "R10");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule